// File: doc/BRIEF.md
# Three-Channel PWM Generator on Two Selectable Timebases

This block drives three pulse-width outputs from two 8-bit period timers. A timer advances either once per instruction cycle or on rising edges of one shared external clock pin. The instruction cycle is four system clocks. The external pin is resynchronized, and a detected edge is only acted upon at the instruction-cycle strobe. Each channel holds a 10-bit duty word. The top 8 bits are compared against the timer count. The 2 fractional bits add quarter-cycle steps of high time, but only while the timebase runs from the internal clock. When the timebase is clocked from the pin, the fractional bits are dropped and the resolution falls to 8 bits.

Software programs the block through a simple write port: address, 8-bit data and a write strobe. Channel 1 is tied to timer 1. Channels 2 and 3 each carry a bit that moves them onto timer 2. Period and duty values written while a timer runs are held in shadow registers and take effect at the next period boundary. While a timer is stopped, its shadows follow the written values.

Register map (wrAddr): 0 = timer control, 1 = channel control, 2/3 = period of timer 1/2, 4/5/6 = duty high byte (duty bits 9..2) of channel 1/2/3, 8/9/10 = duty low byte of channel 1/2/3 (bits 7:6 carry duty bits 1..0).

Top module: `pwm_tribank`

## Requirements
- R1: After reset all control bits are 0, so every PWM output and every period-hit flag is low.
- R2: In internal mode, with timer-control bit t set (bit 0 runs timer 1, bit 1 runs timer 2) and bit 2+t clear, a timer with period value P repeats every 4*(P+1) system clocks. Its periodHit bit is high for exactly one clock per period, in the first clock of the period.
- R3: In internal mode a channel's output is high for D system clocks from the start of each period. D is the 10-bit duty value {high byte, low byte bits 7:6}.
- R4: A duty value of 0 keeps the output low for the whole period.
- R5: A duty value of 4*(P+1) or more keeps the output high for the whole period.
- R6: With timer-control bit 2+t set, the timer advances once per rising edge of extPin. Each edge is taken at an instruction-cycle strobe, and the period spans P+1 edges.
- R7: In external mode the high time is min(H, P+1) timer steps, where H is the duty high byte. Duty low bits 7:6 have no effect.
- R8: Channel 1 always uses timer 1. Channel-control bit 3 moves channel 2 onto timer 2, and bit 4 moves channel 3 onto timer 2.
- R9: Channel-control bit c (c = 0..2) enables output c. A disabled output stays low whatever its duty.
- R10: Period and duty values written while the timer runs take effect only at that timer's next period boundary. The period in progress completes with the old values.
- R11: A timer whose run bit is 0 holds its count and raises no period-hit flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, four per instruction cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 4 | Register address |
| wrData | input | 8 | Register write data |
| extPin | input | 1 | External timer clock, asynchronous |
| pwmOut | output | 3 | PWM outputs, bit c is channel c+1 |
| periodHit | output | 2 | One-clock period-match pulse per timer |

## Verification
A wrong count or a stale period shadow shows up at the latest on the next periodHit pulse, because the measured distance between pulses no longer equals the programmed period. A stale or miscomposed duty shadow changes the measured high time within that same period. A fault in the pin synchronizer or in the pending-edge latch shifts the external period by whole instruction cycles. That shift appears as soon as one full external period has been timed.

// File: rtl/pwm_tribank_pkg.sv
package pwm_tribank_pkg;
  localparam int NumTimers = 2;
  localparam int NumChan   = 3;
  localparam int CntW      = 8;
  localparam int FracW     = 2;
  localparam int DutyW     = CntW + FracW;
  localparam int DataW     = 8;
  localparam int AddrW     = 4;

  localparam logic [AddrW-1:0] AddrTimerCtl = 4'd0;
  localparam logic [AddrW-1:0] AddrChanCtl  = 4'd1;
  localparam int               AddrPeriod0  = 2;
  localparam int               AddrDutyHi0  = 4;
  localparam int               AddrDutyLo0  = 8;

  typedef struct packed {
    logic                 cycStrobe;
    logic [FracW-1:0]     phase;
    logic [NumTimers-1:0] tick;
  } strobe_t;

  typedef struct packed {
    logic [NumTimers-1:0]            run;
    logic [NumTimers-1:0]            extClk;
    logic [NumChan-1:0]              chanEn;
    logic [NumChan-1:0]              useT2;
    logic [NumTimers-1:0][CntW-1:0]  period;
    logic [NumChan-1:0][DutyW-1:0]   duty;
  } cfg_t;
endpackage

// File: rtl/pwm_tribank_ctrl.sv
module pwm_tribank_ctrl
  import pwm_tribank_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrEn,
  input  logic [AddrW-1:0] wrAddr,
  input  logic [DataW-1:0] wrData,
  input  logic             extPin,
  output strobe_t          strobes,
  output cfg_t             cfg
);
  logic [FracW-1:0]       phaseQ;
  logic                   cycStrobe;
  logic [2:0]             pinPipe;
  logic                   riseSeen;
  logic                   pendQ;
  logic                   edgeAvail;
  logic [2*NumTimers-1:0] timerCtlQ;
  logic [2*NumChan-2:0]   chanCtlQ;
  logic [CntW-1:0]        periodQ [NumTimers];
  logic [CntW-1:0]        dutyHiQ [NumChan];
  logic [FracW-1:0]       dutyLoQ [NumChan];

  // instruction-cycle phase counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phaseQ <= '0;
    else        phaseQ <= phaseQ + 1'b1;
  end
  assign cycStrobe = &phaseQ;

  // two-flop synchronizer plus one history flop for edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pinPipe <= '0;
    else        pinPipe <= {pinPipe[1:0], extPin};
  end
  assign riseSeen = pinPipe[1] & ~pinPipe[2];

  // pending edge, consumed at the instruction-cycle strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pendQ <= 1'b0;
    else if (cycStrobe) pendQ <= 1'b0;
    else if (riseSeen)  pendQ <= 1'b1;
  end
  assign edgeAvail = pendQ | riseSeen;

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timerCtlQ <= '0;
      chanCtlQ  <= '0;
    end else if (wrEn) begin
      if (wrAddr == AddrTimerCtl) timerCtlQ <= wrData[2*NumTimers-1:0];
      if (wrAddr == AddrChanCtl)  chanCtlQ  <= wrData[2*NumChan-2:0];
    end
  end

  for (genvar t = 0; t < NumTimers; t++) begin : g_timerRegs
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) periodQ[t] <= '0;
      else if (wrEn && wrAddr == AddrW'(AddrPeriod0 + t)) periodQ[t] <= wrData;
    end
    assign cfg.period[t]    = periodQ[t];
    assign cfg.run[t]       = timerCtlQ[t];
    assign cfg.extClk[t]    = timerCtlQ[NumTimers + t];
    assign strobes.tick[t]  = cycStrobe & timerCtlQ[t] &
                              (timerCtlQ[NumTimers + t] ? edgeAvail : 1'b1);
  end

  for (genvar c = 0; c < NumChan; c++) begin : g_chanRegs
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dutyHiQ[c] <= '0;
        dutyLoQ[c] <= '0;
      end else if (wrEn) begin
        if (wrAddr == AddrW'(AddrDutyHi0 + c)) dutyHiQ[c] <= wrData;
        if (wrAddr == AddrW'(AddrDutyLo0 + c)) dutyLoQ[c] <= wrData[DataW-1 -: FracW];
      end
    end
    assign cfg.duty[c]   = {dutyHiQ[c], dutyLoQ[c]};
    assign cfg.chanEn[c] = chanCtlQ[c];
    if (c == 0) begin : g_fixed
      assign cfg.useT2[c] = 1'b0;
    end else begin : g_sel
      assign cfg.useT2[c] = chanCtlQ[NumChan + c - 1];
    end
  end

  assign strobes.cycStrobe = cycStrobe;
  assign strobes.phase     = phaseQ;
endmodule

// File: rtl/pwm_tribank_dp.sv
module pwm_tribank_dp
  import pwm_tribank_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  strobe_t              strobes,
  input  cfg_t                 cfg,
  output logic [NumChan-1:0]   pwmOut,
  output logic [NumTimers-1:0] periodHit
);
  logic [CntW-1:0]      cntQ  [NumTimers];
  logic [CntW-1:0]      perSh [NumTimers];
  logic [NumTimers-1:0] wrapNow;
  logic [NumTimers-1:0] hitQ;
  logic [DutyW-1:0]     dutySh [NumChan];

  for (genvar t = 0; t < NumTimers; t++) begin : g_timer
    assign wrapNow[t] = strobes.tick[t] && (cntQ[t] == perSh[t]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cntQ[t]  <= '0;
        perSh[t] <= '0;
        hitQ[t]  <= 1'b0;
      end else begin
        hitQ[t] <= wrapNow[t];
        if (strobes.tick[t]) cntQ[t] <= wrapNow[t] ? '0 : cntQ[t] + 1'b1;
        if (!cfg.run[t] || wrapNow[t]) perSh[t] <= cfg.period[t];
      end
    end

    // R2
    match_count_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hitQ[t] |-> cntQ[t] == '0);
    // R11
    stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg.run[t] |=> $stable(cntQ[t]));
    // R6
    count_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cntQ[t] != $past(cntQ[t])) |-> $past(strobes.cycStrobe));
    // R10
    shadow_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cfg.run[t]) && cntQ[t] != '0) |-> $stable(perSh[t]));
  end

  assign periodHit = hitQ;

  for (genvar c = 0; c < NumChan; c++) begin : g_chan
    logic            tSel;
    logic [CntW-1:0] cntSel;
    logic            highNow;

    assign tSel   = cfg.useT2[c];
    assign cntSel = cntQ[tSel];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dutySh[c] <= '0;
      else if (!cfg.run[tSel] || wrapNow[tSel]) dutySh[c] <= cfg.duty[c];
    end

    // external mode drops the fractional bits; internal mode uses all ten
    always_comb begin
      if (cfg.extClk[tSel]) highNow = cntSel < dutySh[c][DutyW-1:FracW];
      else                  highNow = {cntSel, strobes.phase} < dutySh[c];
    end

    assign pwmOut[c] = cfg.chanEn[c] & highNow;

    // R4
    duty_zero_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dutySh[c] == '0) |-> !pwmOut[c]);
  end
endmodule

// File: rtl/pwm_tribank.sv
module pwm_tribank
  import pwm_tribank_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wrEn,
  input  logic [AddrW-1:0]     wrAddr,
  input  logic [DataW-1:0]     wrData,
  input  logic                 extPin,
  output logic [NumChan-1:0]   pwmOut,
  output logic [NumTimers-1:0] periodHit
);
  strobe_t strobes;
  cfg_t    cfg;

  pwm_tribank_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .extPin  (extPin),
    .strobes (strobes),
    .cfg     (cfg)
  );

  pwm_tribank_dp u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobes   (strobes),
    .cfg       (cfg),
    .pwmOut    (pwmOut),
    .periodHit (periodHit)
  );
endmodule

// File: tb/test_pwm_tribank.sv
module test_pwm_tribank;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wrEn = 1'b0;
  logic [3:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic       extPin = 1'b0;
  logic [2:0] pwmOut;
  logic [1:0] periodHit;

  int checks = 0;
  int fails = 0;
  int monC = 0;
  int monT = 0;
  bit measuring = 1'b0;
  int perCnt = 0;
  int hiCnt = 0;
  int extDiv = 0;

  int    qHi[$];
  int    qPer[$];
  string qTagHi[$];
  string qTagPer[$];

  pwm_tribank i_pwm_tribank (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .extPin(extPin), .pwmOut(pwmOut), .periodHit(periodHit)
  );

  always #4 clk = ~clk;

  // external clock: 32 system clocks per cycle, tied to the bench clock
  always @(posedge clk) begin
    extDiv <= (extDiv == 15) ? 0 : extDiv + 1;
    if (extDiv == 15) extPin <= ~extPin;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: times each period of the watched timer and compares with the queue
  always @(negedge clk) begin
    if (rst_n) begin
      if (periodHit[monT]) begin
        if (measuring && qPer.size() > 0) begin
          automatic int eHi = qHi.pop_front();
          automatic int ePer = qPer.pop_front();
          automatic string tH = qTagHi.pop_front();
          automatic string tP = qTagPer.pop_front();
          check(perCnt == ePer, tP, perCnt, ePer);
          check(hiCnt == eHi, tH, hiCnt, eHi);
        end
        measuring = (qPer.size() > 0);
        perCnt = 0;
        hiCnt = 0;
      end
      perCnt++;
      if (pwmOut[monC]) hiCnt++;
    end
  end

  task automatic writeReg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitHits(input int n);
    for (int i = 0; i < n; i++) begin
      do @(negedge clk); while (!periodHit[monT]);
    end
  endtask

  task automatic expectItem(input int hi, input int per, input string tagHi, input string tagPer);
    qHi.push_back(hi);
    qPer.push_back(per);
    qTagHi.push_back(tagHi);
    qTagPer.push_back(tagPer);
  endtask

  task automatic measure(input int hi, input int per, input string tagHi, input string tagPer);
    waitHits(2);
    @(posedge clk);
    expectItem(hi, per, tagHi, tagPer);
    wait (qPer.size() == 0);
  endtask

  task automatic setDuty(input int ch, input logic [7:0] hi, input logic [7:0] lo);
    writeReg(4'(4 + ch), hi);
    writeReg(4'(8 + ch), lo);
  endtask

  initial begin
    int hitCount;
    logic [2:0] heldOut;
    int changes;
    repeat (5) @(negedge clk);
    // R1: reset state
    check(pwmOut == 3'b000, "R1 pwmOut", int'(pwmOut), 0);
    check(periodHit == 2'b00, "R1 periodHit", int'(periodHit), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(pwmOut == 3'b000, "R1 pwmOut after release", int'(pwmOut), 0);

    // internal mode on timer 1, channel 1
    writeReg(4'd2, 8'd9);
    setDuty(0, 8'd5, 8'h80);
    writeReg(4'd1, 8'h01);
    writeReg(4'd0, 8'h01);
    monC = 0; monT = 0;
    waitHits(1);
    hitCount = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (periodHit[0]) hitCount++;
    end
    check(hitCount == 10, "R2 hit pulses in 400 clocks", hitCount, 10);
    measure(22, 40, "R3 high time", "R2 period");

    setDuty(0, 8'd9, 8'hC0);
    measure(39, 40, "R3 high time 39", "R2 period");
    setDuty(0, 8'd0, 8'h00);
    measure(0, 40, "R4 zero duty", "R2 period");
    setDuty(0, 8'd10, 8'h00);
    measure(40, 40, "R5 duty equals period", "R2 period");
    setDuty(0, 8'hFF, 8'hC0);
    measure(40, 40, "R5 duty above period", "R2 period");

    // external mode on timer 1
    setDuty(0, 8'd4, 8'hC0);
    writeReg(4'd0, 8'h05);
    measure(128, 320, "R7 low bits ignored", "R6 external period");
    setDuty(0, 8'd4, 8'h00);
    measure(128, 320, "R7 low bits zero", "R6 external period");
    setDuty(0, 8'd20, 8'h00);
    measure(320, 320, "R7 high byte above period", "R6 external period");

    // timebase selection
    writeReg(4'd0, 8'h03);
    writeReg(4'd3, 8'd4);
    setDuty(1, 8'd2, 8'h40);
    writeReg(4'd1, 8'h0B);
    monC = 1; monT = 1;
    measure(9, 20, "R8 ch2 on timer2 high", "R8 ch2 on timer2 period");
    writeReg(4'd1, 8'h03);
    monT = 0;
    measure(9, 40, "R8 ch2 on timer1 high", "R8 ch2 on timer1 period");
    setDuty(2, 8'd3, 8'h00);
    writeReg(4'd1, 8'h15);
    monC = 2; monT = 1;
    measure(12, 20, "R8 ch3 on timer2 high", "R8 ch3 on timer2 period");

    // output enable
    setDuty(0, 8'd5, 8'h80);
    writeReg(4'd1, 8'h14);
    monC = 0; monT = 0;
    measure(0, 40, "R9 disabled channel", "R2 period");
    writeReg(4'd1, 8'h15);
    measure(22, 40, "R9 re-enabled channel", "R2 period");

    // R10: mid-period update applies at the next boundary
    waitHits(1);
    @(posedge clk);
    expectItem(22, 40, "R10 old duty kept", "R10 old period kept");
    expectItem(30, 60, "R10 new duty", "R10 new period");
    waitHits(1);
    repeat (10) @(negedge clk);
    setDuty(0, 8'd7, 8'h80);
    writeReg(4'd2, 8'd14);
    wait (qPer.size() == 0);

    // R11: stopped timer
    writeReg(4'd0, 8'h02);
    repeat (10) @(negedge clk);
    heldOut = pwmOut;
    hitCount = 0;
    changes = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (periodHit[0]) hitCount++;
      if (pwmOut[0] != heldOut[0]) changes++;
    end
    check(hitCount == 0, "R11 no hits while stopped", hitCount, 0);
    check(changes == 0, "R11 output frozen while stopped", changes, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule